// File: doc/BRIEF.md
# Butterfly First-Order Reed-Muller Encoder

This block turns a first-order Reed-Muller message into its full codeword. There is no generator matrix and no per-row selection. The message bits are written into fixed single-bit slots of an otherwise zero word. The word then passes through `M` butterfly stages. Each stage XORs a masked, left-shifted copy of the word into itself. The masks and shift amounts are constants, so the same operations run for every message value. No message bit drives a select, an enable or an index.

The parameter `M` sets the code size:

| M | Message width | Codeword width |
|---|---------------|----------------|
| 7 | 8 bits | 128 bits |
| 8 | 9 bits | 256 bits |

The parameter `MODE` sets the timing:

- **Pipelined:** one register after every stage.
- **Combinational:** the whole network in one path.
- **Combinational with output register:** the whole network in one path, followed by a single output register.

The parameter `ORDER` runs the stages from the lowest axis up or from the highest axis down. Both orders give the same codeword, because the stages work on independent axes.

A producer presents a message together with `msg_valid`. The codeword appears on `cw` together with `cw_valid`, after a latency fixed by `MODE`.

Top module: `rm_bfly_enc`

## Requirements
- R1: With `M`=7 the message input is 8 bits and the codeword 128 bits. With `M`=8 the message input is 9 bits and the codeword 256 bits.
- R2: Message bit 0 is the constant term. Message bit i (1 ≤ i ≤ `M`) weights address bit i-1. Codeword bit x equals msg[0] XOR the XOR, over i, of (msg[i] AND bit i-1 of x).
- R3: An all-zero message gives an all-zero codeword. A message with only bit 0 set gives an all-ones codeword.
- R4: A message with only bit i set gives the codeword whose bit x is bit i-1 of x. For `M`=7 this is hex AA repeated for bit 1, CC repeated for bit 2, F0 repeated for bit 3, and ones in the upper 64 bits for bit 7.
- R5: Ascending and descending stage order (`ORDER`) give identical codewords for every message.
- R6: In pipelined mode, `cw_valid` and `cw` follow the corresponding `msg_valid` and `msg` by exactly `M` clock cycles. Back-to-back messages and gaps are both carried through.
- R7: In combinational mode, `cw_valid` equals `msg_valid` and `cw` is the codeword of `msg` in the same cycle.
- R8: In combinational mode with output register, the codeword and its valid strobe appear one clock cycle after the message.
- R9: A synchronous active-high `rst` clears every pipeline register. One cycle after `rst` is sampled high, a registered output shows `cw_valid` low and `cw` all zero, even if a message was in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message present this cycle |
| msg | input | M+1 | Message; bit 0 is the constant term |
| cw_valid | output | 1 | Codeword present this cycle |
| cw | output | 2**M | Reed-Muller codeword |

## Verification
A wrong mask or shift in any stage corrupts a fixed set of codeword bits for every message that sets the affected inputs. Single-bit messages expose such a fault in the first codeword that carries one. Exhaustive streaming through all messages exposes any remaining difference. The codeword shows up `M` cycles after the message in pipelined mode, and in the same or next cycle in the combinational modes.

Two faults show up on `cw_valid` at its very next assertion. A dropped or extra pipeline register moves the strobe away from its expected cycle. A valid bit that is not cleared by reset shows as a stray strobe straight after reset. Comparing ascending against descending stage order catches a stage that depends on its neighbours.

// File: rtl/rm_bfly_pkg.sv
package rm_bfly_pkg;

    localparam int unsigned RM_MAX_M = 8;
    localparam int unsigned RM_MAX_N = 1 << RM_MAX_M;

    typedef enum logic {
        ORDER_ASCENDING  = 1'b0,
        ORDER_DESCENDING = 1'b1
    } stage_order_e;

    typedef enum logic [1:0] {
        MODE_COMB     = 2'd0,
        MODE_COMB_REG = 2'd1,
        MODE_PIPE     = 2'd2
    } timing_mode_e;

    // Cycles from message to codeword for a given timing mode
    function automatic int unsigned enc_latency(input int unsigned m, input timing_mode_e mode);
        case (mode)
            MODE_PIPE:     return m;
            MODE_COMB_REG: return 1;
            default:       return 0;
        endcase
    endfunction

    // Positions whose index has bit 'axis' clear are the sources of a stage
    function automatic logic [RM_MAX_N-1:0] axis_mask(input int unsigned axis);
        logic [RM_MAX_N-1:0] r;
        for (int x = 0; x < RM_MAX_N; x++) begin
            r[x] = (((x >> axis) & 1) == 0);
        end
        return r;
    endfunction

    // Axis handled by pipeline slot s under a given order
    function automatic int unsigned stage_axis(input int unsigned s, input int unsigned m,
                                               input stage_order_e order);
        return (order == ORDER_DESCENDING) ? (m - 1 - s) : s;
    endfunction

endpackage

// File: rtl/rm_bfly_inject.sv
module rm_bfly_inject
    import rm_bfly_pkg::*;
#(
    parameter int unsigned M = 7,
    localparam int unsigned MW = M + 1,
    localparam int unsigned N  = 1 << M
) (
    input  logic [MW-1:0] msg,
    output logic [N-1:0]  word
);

    // Constant term at position 0, bit i at position 2^(i-1); fixed wiring only
    always_comb begin
        word    = '0;
        word[0] = msg[0];
        for (int i = 1; i <= M; i++) begin
            word[1 << (i - 1)] = msg[i];
        end
    end

endmodule

// File: rtl/rm_bfly_stage.sv
module rm_bfly_stage
    import rm_bfly_pkg::*;
#(
    parameter int unsigned N    = 128,
    parameter int unsigned AXIS = 0
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    localparam logic [RM_MAX_N-1:0] MASK_ALL = axis_mask(AXIS);
    localparam logic [N-1:0]        KEEP     = MASK_ALL[N-1:0];
    localparam int unsigned         SHIFT    = 1 << AXIS;

    // Unconditional shift-and-XOR along one hypercube axis
    assign dout = din ^ ((din & KEEP) << SHIFT);

endmodule

// File: rtl/rm_bfly_vreg.sv
module rm_bfly_vreg #(
    parameter int unsigned W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din_vld,
    input  logic [W-1:0] din,
    output logic         dout_vld,
    output logic [W-1:0] dout
);

    // Data loads every cycle regardless of the strobe: no value-dependent enable
    always_ff @(posedge clk) begin
        if (rst) begin
            dout_vld <= 1'b0;
            dout     <= '0;
        end else begin
            dout_vld <= din_vld;
            dout     <= din;
        end
    end

endmodule

// File: rtl/rm_bfly_enc.sv
module rm_bfly_enc
    import rm_bfly_pkg::*;
#(
    parameter int unsigned  M     = 7,
    parameter timing_mode_e MODE  = MODE_PIPE,
    parameter stage_order_e ORDER = ORDER_ASCENDING,
    localparam int unsigned MW = M + 1,
    localparam int unsigned N  = 1 << M
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msg_valid,
    input  logic [MW-1:0] msg,
    output logic          cw_valid,
    output logic [N-1:0]  cw
);

    logic [N-1:0] word [0:M];
    logic         vld  [0:M];

    rm_bfly_inject #(.M(M)) u_inject (
        .msg  (msg),
        .word (word[0])
    );
    assign vld[0] = msg_valid;

    for (genvar s = 0; s < M; s++) begin : g_slot
        localparam int unsigned AXIS = stage_axis(s, M, ORDER);
        logic [N-1:0] mixed;

        rm_bfly_stage #(.N(N), .AXIS(AXIS)) u_stage (
            .din  (word[s]),
            .dout (mixed)
        );

        if (MODE == MODE_PIPE) begin : g_reg
            rm_bfly_vreg #(.W(N)) u_reg (
                .clk      (clk),
                .rst      (rst),
                .din_vld  (vld[s]),
                .din      (mixed),
                .dout_vld (vld[s+1]),
                .dout     (word[s+1])
            );
        end else begin : g_wire
            assign word[s+1] = mixed;
            assign vld[s+1]  = vld[s];
        end
    end

    if (MODE == MODE_COMB_REG) begin : g_out_reg
        rm_bfly_vreg #(.W(N)) u_out (
            .clk      (clk),
            .rst      (rst),
            .din_vld  (vld[M]),
            .din      (word[M]),
            .dout_vld (cw_valid),
            .dout     (cw)
        );
    end else begin : g_out_wire
        assign cw_valid = vld[M];
        assign cw       = word[M];
    end

endmodule

// File: rtl/rm_bfly_enc_chk.sv
module rm_bfly_enc_chk
    import rm_bfly_pkg::*;
#(
    parameter int unsigned  M    = 7,
    parameter timing_mode_e MODE = MODE_PIPE,
    localparam int unsigned MW  = M + 1,
    localparam int unsigned N   = 1 << M,
    localparam int unsigned LAT = enc_latency(M, MODE)
) (
    input logic          clk,
    input logic          rst,
    input logic          msg_valid,
    input logic [MW-1:0] msg,
    input logic          cw_valid,
    input logic [N-1:0]  cw
);

    localparam logic [3:0] LAT4 = 4'(LAT);

    // Generator-row reference, independent of the butterfly
    function automatic logic [N-1:0] row_sum(input logic [MW-1:0] v);
        logic [N-1:0] r;
        r = v[0] ? '1 : '0;
        for (int i = 1; i <= M; i++) begin
            if (v[i]) begin
                for (int x = 0; x < N; x++) begin
                    if (((x >> (i - 1)) & 1) == 1) r[x] = ~r[x];
                end
            end
        end
        return r;
    endfunction

    logic [MW-1:0] h_msg [0:LAT];
    logic          h_vld [0:LAT];
    logic [3:0]    warm_cnt;
    logic          warm;

    assign h_msg[0] = msg;
    assign h_vld[0] = msg_valid;

    for (genvar k = 1; k <= LAT; k++) begin : g_hist
        always_ff @(posedge clk) begin
            h_msg[k] <= h_msg[k-1];
            h_vld[k] <= h_vld[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               warm_cnt <= '0;
        else if (!warm)        warm_cnt <= warm_cnt + 4'd1;
    end
    assign warm = (warm_cnt >= LAT4);

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        cw_valid == (warm ? h_vld[LAT] : 1'b0));                                    // R6

    AST_CODEWORD_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && warm) |-> (cw == row_sum(h_msg[LAT])));                        // R2

    AST_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && warm && h_msg[LAT] == MW'(1)) |-> (cw == '1));                 // R3

    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && warm && h_msg[LAT] == '0) |-> (cw == '0));                     // R3

    if (LAT > 0) begin : g_reg_checks
        AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !cw_valid);                                              // R9
        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (cw == '0));                                             // R9
    end

endmodule

bind rm_bfly_enc rm_bfly_enc_chk #(.M(M), .MODE(MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg       (msg),
    .cw_valid  (cw_valid),
    .cw        (cw)
);

// File: tb/rm_bfly_enc_tb_top.sv
module rm_bfly_enc_tb_top;
    import rm_bfly_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msg_valid = 1'b0;
    logic [7:0] msg7 = '0;
    logic [8:0] msg8 = '0;

    always #4 clk = ~clk;   // 125 MHz

    logic v_a, v_r, v_c, v_q, v_8;
    logic [127:0] cw_a, cw_r, cw_c, cw_q;
    logic [255:0] cw_8;

    rm_bfly_enc #(.M(7), .MODE(MODE_PIPE), .ORDER(ORDER_ASCENDING)) dut_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg(msg7), .cw_valid(v_a), .cw(cw_a));
    rm_bfly_enc #(.M(7), .MODE(MODE_PIPE), .ORDER(ORDER_DESCENDING)) dut_rev_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg(msg7), .cw_valid(v_r), .cw(cw_r));
    rm_bfly_enc #(.M(7), .MODE(MODE_COMB), .ORDER(ORDER_ASCENDING)) dut_comb_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg(msg7), .cw_valid(v_c), .cw(cw_c));
    rm_bfly_enc #(.M(7), .MODE(MODE_COMB_REG), .ORDER(ORDER_DESCENDING)) dut_creg_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg(msg7), .cw_valid(v_q), .cw(cw_q));
    rm_bfly_enc #(.M(8), .MODE(MODE_PIPE), .ORDER(ORDER_ASCENDING)) dut8_i (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg(msg8), .cw_valid(v_8), .cw(cw_8));

    typedef struct packed {
        logic [7:0]   m;
        logic [127:0] cw;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{8'h00, 128'h0},                                  // R3 zero
        '{8'h01, {128{1'b1}}},                             // R3 ones
        '{8'h02, {16{8'hAA}}},                             // R4 bit 1
        '{8'h04, {16{8'hCC}}},                             // R4 bit 2
        '{8'h08, {16{8'hF0}}},                             // R4 bit 3
        '{8'h10, {8{16'hFF00}}},                           // R4 bit 4
        '{8'h40, {2{64'hFFFFFFFF_00000000}}},              // R4 bit 6
        '{8'h80, {{64{1'b1}}, 64'h0}},                     // R4 bit 7
        '{8'h03, {16{8'h55}}}                              // R2 mixed
    };

    int n_cmp = 0;
    int n_bad = 0;
    int step  = 0;
    logic [8:0] hist_msg [0:1199];
    logic       hist_v   [0:1199];
    bit done = 1'b0;

    // Sum of generator rows selected by the message bits
    function automatic logic [255:0] gen_rows(input logic [8:0] v, input int m);
        logic [255:0] r;
        r = '0;
        for (int x = 0; x < (1 << m); x++) begin
            logic b;
            b = v[0];
            for (int i = 1; i <= m; i++) b = b ^ (v[i] & x[i-1]);
            r[x] = b;
        end
        return r;
    endfunction

    task automatic check_stream(input string tag, input logic got_v, input logic [255:0] got_cw,
                                input int lat, input int m);
        int idx;
        logic ev;
        logic [255:0] ecw;
        idx = step - lat;
        ev  = (idx >= 0) ? hist_v[idx] : 1'b0;
        ecw = (idx >= 0) ? gen_rows(hist_msg[idx], m) : '0;
        n_cmp++;
        if (got_v !== ev || (ev && got_cw !== ecw)) begin
            n_bad++;
            $display("FAIL %s step %0d: valid=%b cw=%h expected valid=%b cw=%h",
                     tag, step, got_v, got_cw, ev, ecw);
        end
    endtask

    task automatic check_eq(input string tag, input logic [255:0] got, input logic [255:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 1200; i++) begin
            hist_v[i]   = 1'b0;
            hist_msg[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R9: reset state of every registered output
        check_eq("R9 reset pipe valid",   {255'b0, v_a}, 256'b0);
        check_eq("R9 reset pipe cw",      {128'b0, cw_a}, 256'b0);
        check_eq("R9 reset creg valid",   {255'b0, v_q}, 256'b0);
        check_eq("R9 reset m8 cw",        cw_8, 256'b0);
        rst = 1'b0;

        // Exhaustive streaming: two passes with complementary gaps
        for (int k = 0; k < 1040; k++) begin
            logic v;
            @(negedge clk);
            step = k;
            check_stream("R2/R6 pipe asc",   v_a, {128'b0, cw_a}, 7, 7);
            check_stream("R5 pipe desc",     v_r, {128'b0, cw_r}, 7, 7);
            check_stream("R8 comb reg",      v_q, {128'b0, cw_q}, 1, 7);
            check_stream("R1/R6 m8 pipe",    v_8, cw_8,           8, 8);
            if (k < 512)       v = ((k % 7) != 3);
            else if (k < 1024) v = ((k % 7) == 3);
            else               v = 1'b0;
            hist_v[k]   = v;
            hist_msg[k] = 9'(k % 512);
            msg_valid   = v;
            msg8        = 9'(k % 512);
            msg7        = 8'(k % 256);
            #1;
            check_stream("R7 comb", v_c, {128'b0, cw_c}, 0, 7);
        end

        // Directed single-bit and corner messages
        for (int j = 0; j < NVEC; j++) begin
            @(negedge clk);
            msg_valid = 1'b1;
            msg7 = VECS[j].m;
            #1;
            check_eq($sformatf("R3/R4 table %0d comb", j), {128'b0, cw_c}, {128'b0, VECS[j].cw});
            check_eq("R1 width m7", {255'b0, (cw_c == cw_c)}, 256'd1);
        end
        // R5 on the same directed message through both orders
        repeat (8) @(negedge clk);
        check_eq("R5 asc vs desc", {128'b0, cw_a}, {128'b0, cw_r});
        check_eq("R4 pipe last vector", {128'b0, cw_a}, {128'b0, VECS[NVEC-1].cw});

        // R9: reset with messages in flight
        @(negedge clk);
        msg7 = 8'hFF;
        msg8 = 9'h1FF;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_eq("R9 flight pipe valid", {254'b0, v_a, v_r}, 256'b0);
        check_eq("R9 flight pipe cw",    {128'b0, cw_a}, 256'b0);
        check_eq("R9 flight creg",       {127'b0, v_q, cw_q}, 256'b0);
        check_eq("R9 flight m8",         {255'b0, v_8}, 256'b0);
        msg_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule